// File: doc/BRIEF.md
# Programmable Synthesizer Serial Loader

This block programs up to three external frequency synthesizers over one serial data line, one serial clock line and one latch strobe per synthesizer. A processor sets up a data word, a bit count, a bit order, a clock polarity, a latch-line mask and two tick positions that shape the serial clock. It then pulses `start`. The loader shifts the selected bits out one bit period at a time. After the last bit it raises the chosen latch lines for one full bit period and then reports that it is free again.

Every bit period is `2**TICK_W` clock cycles long. Within a period the serial clock is active from tick `rise_at` up to, but not including, tick `fall_at`. A word longer than one cycle can carry is sent in several cycles with an empty latch mask, and the latch mask is set only on the final cycle. All fields are captured when `start` is accepted, so the processor may rewrite them while a cycle is running.

Top module: `synth_serial_loader`

## Requirements
- R1: While reset is held, and after it is released, `ready` is 1 and `ser_clk`, `ser_data` and `latch_en` are all 0.
- R2: When `start` is sampled high while `ready` is 1, `ready` is 0 from the next cycle. It stays 0 for (N+1)*P+1 cycles, where N is the captured `bit_count` and P = 2**TICK_W. It reads 1 again in the cycle in which the latch pulse has ended.
- R3: A `start` sampled while `ready` is 0 is ignored and leaves the running cycle's waveform unchanged.
- R4: A cycle sends exactly N bits, each lasting P clock cycles. The outputs show the first tick of bit 0 two cycles after the accepting edge, that is, in the second sample after `ready` falls.
- R5: With `lsb_first` = 1, bit k sent is `load_word[k]`. With `lsb_first` = 0, bit k sent is `load_word[N-1-k]`. `ser_data` holds the bit for its whole period.
- R6: Within a bit period at tick t (0..P-1), the uninverted serial clock is 1 exactly when `rise_at` <= t < `fall_at`.
- R7: With `clk_invert` = 1, the serial clock is the complement of the R6 waveform. Outside a cycle, `ser_clk` rests at the `clk_invert` value of the last accepted cycle, which is 0 after reset.
- R8: After the last bit, each `latch_en[i]` with `le_select[i]` = 1 is high for exactly P cycles. During that time `ser_data` is 0 and `ser_clk` rests at its idle level.
- R9: With N = 0 the cycle is a latch pulse only. With `le_select` = 0 the bits are sent and no latch line pulses, but the latch period is still spent.
- R10: Changes to `load_word`, `bit_count`, `lsb_first`, `clk_invert`, `le_select`, `rise_at` or `fall_at` after the accepting edge have no effect on the running cycle.
- R11: `ser_data` and all `latch_en` lines are 0 whenever `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a programming cycle (taken only when ready) |
| load_word | input | DATA_W | Data word to send |
| bit_count | input | CNT_W | Number of bits to send, 0..DATA_W-1 |
| lsb_first | input | 1 | 1: send bit 0 first; 0: send bit N-1 first |
| clk_invert | input | 1 | 1: invert serial clock and its idle level |
| le_select | input | LE_N | Mask of latch lines to pulse at cycle end |
| rise_at | input | TICK_W | Tick at which the serial clock turns active |
| fall_at | input | TICK_W | Tick at which the serial clock turns inactive |
| ready | output | 1 | Loader idle, a new start will be taken |
| ser_clk | output | 1 | Serial clock to the synthesizers |
| ser_data | output | 1 | Serial data to the synthesizers |
| latch_en | output | LE_N | Latch strobes, one per synthesizer |

## Verification
Two events can meet in one cycle: the end of a latch pulse and a new start request. They meet when `start` is held high through the tail of a cycle. The request must then be refused in the tail cycle, where `ready` is still 0, and taken on the very next edge, where `ready` has just returned to 1. A behavioural reference model builds the expected per-cycle waveform at each acceptance and compares `ready`, `ser_clk`, `ser_data` and `latch_en` on every clock. A skipped or early acceptance therefore shows up as a shifted waveform. The bench also fires a start request and rewrites every field in the middle of a transfer, and the model expects the transfer to continue untouched.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
   typedef enum logic [1:0] {
      SSL_IDLE  = 2'd0,
      SSL_SHIFT = 2'd1,
      SSL_LATCH = 2'd2,
      SSL_TAIL  = 2'd3
   } ssl_state_e;
endpackage

// File: rtl/ssl_sequencer.sv
module ssl_sequencer
   import ssl_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int TICK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CNT_W-1:0]  n_req,
   input  logic [CNT_W-1:0]  n_cur,
   output ssl_state_e        state,
   output logic [TICK_W-1:0] tick,
   output logic [CNT_W-1:0]  bidx
);
   localparam logic [TICK_W-1:0] TICK_LAST = '1;
   localparam logic [CNT_W-1:0]  ONE_C     = CNT_W'(1);

   logic last_bit;
   assign last_bit = (bidx == (n_cur - ONE_C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SSL_IDLE;
         tick  <= '0;
         bidx  <= '0;
      end else begin
         unique case (state)
            SSL_IDLE: begin
               if (accept) begin
                  state <= (n_req == '0) ? SSL_LATCH : SSL_SHIFT;
                  tick  <= '0;
                  bidx  <= '0;
               end
            end
            SSL_SHIFT: begin
               tick <= tick + TICK_W'(1);
               if (tick == TICK_LAST) begin
                  if (last_bit) state <= SSL_LATCH;
                  else          bidx  <= bidx + ONE_C;
               end
            end
            SSL_LATCH: begin
               tick <= tick + TICK_W'(1);
               if (tick == TICK_LAST) state <= SSL_TAIL;
            end
            default: state <= SSL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ssl_bit_pick.sv
module ssl_bit_pick #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5
) (
   input  logic [DATA_W-1:0] word,
   input  logic [CNT_W-1:0]  n_bits,
   input  logic [CNT_W-1:0]  bidx,
   input  logic              lsb_first,
   output logic              bit_o
);
   logic [CNT_W-1:0] idx;
   assign idx   = lsb_first ? bidx : (n_bits - CNT_W'(1) - bidx);
   assign bit_o = word[idx];
endmodule

// File: rtl/ssl_clk_shape.sv
module ssl_clk_shape #(
   parameter int TICK_W = 4
) (
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] rise_at,
   input  logic [TICK_W-1:0] fall_at,
   input  logic              invert,
   output logic              level
);
   logic active;
   assign active = (tick >= rise_at) && (tick < fall_at);
   assign level  = active ^ invert;
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
   import ssl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TICK_W = 4,
   parameter int LE_N   = 3,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_word,
   input  logic [CNT_W-1:0]  bit_count,
   input  logic              lsb_first,
   input  logic              clk_invert,
   input  logic [LE_N-1:0]   le_select,
   input  logic [TICK_W-1:0] rise_at,
   input  logic [TICK_W-1:0] fall_at,
   output logic              ready,
   output logic              ser_clk,
   output logic              ser_data,
   output logic [LE_N-1:0]   latch_en
);
   generate
      if (DATA_W < 2 || DATA_W != (1 << CNT_W)) begin : g_bad_data_w
         $error("synth_serial_loader: DATA_W must be a power of two, at least 2");
      end
      if (TICK_W < 1) begin : g_bad_tick_w
         $error("synth_serial_loader: TICK_W must be at least 1");
      end
      if (LE_N < 1) begin : g_bad_le_n
         $error("synth_serial_loader: LE_N must be at least 1");
      end
   endgenerate

   ssl_state_e        state;
   logic [TICK_W-1:0] tick;
   logic [CNT_W-1:0]  bidx;
   logic              accept;

   logic [DATA_W-1:0] word_s;
   logic [CNT_W-1:0]  n_s;
   logic              lsb_s, inv_s;
   logic [LE_N-1:0]   sel_s;
   logic [TICK_W-1:0] rise_s, fall_s;

   assign accept = start && (state == SSL_IDLE);
   assign ready  = (state == SSL_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_s <= '0;
         n_s    <= '0;
         lsb_s  <= 1'b0;
         inv_s  <= 1'b0;
         sel_s  <= '0;
         rise_s <= '0;
         fall_s <= '0;
      end else if (accept) begin
         word_s <= load_word;
         n_s    <= bit_count;
         lsb_s  <= lsb_first;
         inv_s  <= clk_invert;
         sel_s  <= le_select;
         rise_s <= rise_at;
         fall_s <= fall_at;
      end
   end

   ssl_sequencer #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .n_req  (bit_count),
      .n_cur  (n_s),
      .state  (state),
      .tick   (tick),
      .bidx   (bidx)
   );

   logic cur_bit;
   ssl_bit_pick #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pick (
      .word      (word_s),
      .n_bits    (n_s),
      .bidx      (bidx),
      .lsb_first (lsb_s),
      .bit_o     (cur_bit)
   );

   logic shaped_clk;
   ssl_clk_shape #(.TICK_W(TICK_W)) u_shape (
      .tick    (tick),
      .rise_at (rise_s),
      .fall_at (fall_s),
      .invert  (inv_s),
      .level   (shaped_clk)
   );

   logic            in_shift, in_latch;
   logic [LE_N-1:0] le_next;
   assign in_shift = (state == SSL_SHIFT);
   assign in_latch = (state == SSL_LATCH);

   generate
      for (genvar gi = 0; gi < LE_N; gi++) begin : g_le
         assign le_next[gi] = in_latch && sel_s[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_clk  <= 1'b0;
         ser_data <= 1'b0;
         latch_en <= '0;
      end else begin
         ser_clk  <= in_shift ? shaped_clk : inv_s;
         ser_data <= in_shift && cur_bit;
         latch_en <= le_next;
      end
   end
endmodule

// File: rtl/ssl_chk.sv
module ssl_chk #(
   parameter int LE_N = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            ready,
   input logic            ser_clk,
   input logic            ser_data,
   input logic [LE_N-1:0] latch_en
);
   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(start));

   // R8
   latch_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en != '0) |-> !ser_data);

   // R8
   latch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en != '0) |-> !ready);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!ser_data && (latch_en == '0)));

   // R7
   idle_clk_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready)) |-> $stable(ser_clk));

   // R8
   latch_mask_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((latch_en != '0) && ($past(latch_en) != '0)) |-> $stable(latch_en));
endmodule

bind synth_serial_loader ssl_chk #(.LE_N(LE_N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ready    (ready),
   .ser_clk  (ser_clk),
   .ser_data (ser_data),
   .latch_en (latch_en)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 5;
   localparam int TICK_W = 4;
   localparam int LE_N   = 3;
   localparam int P      = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [DATA_W-1:0] load_word = '0;
   logic [CNT_W-1:0]  bit_count = '0;
   logic              lsb_first = 1'b0;
   logic              clk_invert = 1'b0;
   logic [LE_N-1:0]   le_select = '0;
   logic [TICK_W-1:0] rise_at = '0;
   logic [TICK_W-1:0] fall_at = '0;
   logic              ready, ser_clk, ser_data;
   logic [LE_N-1:0]   latch_en;

   synth_serial_loader #(.DATA_W(DATA_W), .TICK_W(TICK_W), .LE_N(LE_N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .load_word(load_word),
      .bit_count(bit_count), .lsb_first(lsb_first), .clk_invert(clk_invert),
      .le_select(le_select), .rise_at(rise_at), .fall_at(fall_at),
      .ready(ready), .ser_clk(ser_clk), .ser_data(ser_data), .latch_en(latch_en)
   );

   always #5 clk = ~clk;

   int    compared = 0;
   int    mismatched = 0;
   string tag = "R1 reset";
   bit    done = 1'b0;

   // frame layout: {ready, latch_en[2:0], ser_data, ser_clk}
   logic [5:0] exp_f = 6'b100000;
   logic [5:0] fq[$];
   bit         last_pol = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         fq.delete();
         last_pol = 1'b0;
         exp_f = 6'b100000;
      end else begin
         if (exp_f[5] && start) begin
            int n;
            int hi;
            int lo;
            n  = int'(bit_count);
            hi = int'(rise_at);
            lo = int'(fall_at);
            fq.push_back({1'b0, 3'b000, 1'b0, last_pol});
            for (int k = 0; k < n; k++) begin
               for (int t = 0; t < P; t++) begin
                  bit b, a;
                  b = lsb_first ? load_word[k] : load_word[n-1-k];
                  a = (t >= hi) && (t < lo);
                  fq.push_back({1'b0, 3'b000, b, a ^ clk_invert});
               end
            end
            for (int t = 0; t < P; t++)
               fq.push_back({1'b0, le_select, 1'b0, clk_invert});
            last_pol = clk_invert;
         end
         if (fq.size() > 0) exp_f = fq.pop_front();
         else               exp_f = {1'b1, 3'b000, 1'b0, last_pol};
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         bit bad;
         bad = 1'b0;
         compared++;
         if (ready !== exp_f[5]) begin
            bad = 1'b1;
            $display("FAIL %s ready (R2) t=%0t got %b exp %b", tag, $time, ready, exp_f[5]);
         end
         if (latch_en !== exp_f[4:2]) begin
            bad = 1'b1;
            $display("FAIL %s latch_en (R8) t=%0t got %b exp %b", tag, $time, latch_en, exp_f[4:2]);
         end
         if (ser_data !== exp_f[1]) begin
            bad = 1'b1;
            $display("FAIL %s ser_data (R5) t=%0t got %b exp %b", tag, $time, ser_data, exp_f[1]);
         end
         if (ser_clk !== exp_f[0]) begin
            bad = 1'b1;
            $display("FAIL %s ser_clk (R6 R7) t=%0t got %b exp %b", tag, $time, ser_clk, exp_f[0]);
         end
         if (bad) mismatched++;
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   task automatic setup(input logic [DATA_W-1:0] w, input int n, input bit lsb,
                        input bit inv, input logic [LE_N-1:0] sel, input int hi, input int lo);
      load_word  = w;
      bit_count  = CNT_W'(n);
      lsb_first  = lsb;
      clk_invert = inv;
      le_select  = sel;
      rise_at    = TICK_W'(hi);
      fall_at    = TICK_W'(lo);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_ready();
      while (!ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 R5 R6 R8: MSB first, normal polarity, line 0
      tag = "R4 R5 R6 R8 msb";
      setup(32'h0000_00A5, 8, 1'b0, 1'b0, 3'b001, 4, 12);
      pulse_start();
      wait_ready();

      // R5 R7: LSB first, inverted clock, line 2, clock from tick 0
      tag = "R5 R7 lsb inverted";
      setup(32'h0000_0013, 5, 1'b1, 1'b1, 3'b100, 0, 8);
      pulse_start();
      wait_ready();

      // R3 R10: start and field rewrites during a transfer are ignored
      tag = "R3 R10 busy";
      setup(32'h0000_3C96, 14, 1'b0, 1'b0, 3'b010, 2, 9);
      pulse_start();
      repeat (40) @(negedge clk);
      setup(32'hFFFF_FFFF, 3, 1'b1, 1'b1, 3'b111, 0, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      setup(32'h0000_0000, 30, 1'b1, 1'b0, 3'b100, 5, 6);
      wait_ready();

      // R9: zero bits, latch pulse only
      tag = "R9 zero bits";
      setup(32'hDEAD_BEEF, 0, 1'b0, 1'b0, 3'b010, 3, 10);
      pulse_start();
      wait_ready();

      // R9: full-length word, no latch line
      tag = "R9 no latch long";
      setup(32'h5A3C_F00F, 31, 1'b0, 1'b1, 3'b000, 1, 15);
      pulse_start();
      wait_ready();

      // R2: start held through the tail, re-accepted the cycle ready returns
      tag = "R2 back-to-back";
      setup(32'h0000_0006, 3, 1'b1, 1'b0, 3'b011, 8, 4);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      while (!ready) @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_ready();

      // R11 R1: stays quiet while idle
      tag = "R11 idle";
      repeat (10) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog (R2) t=%0t got busy exp ready", $time);
      finish_run();
   end
endmodule